// File: doc/BRIEF.md
# RDS Block Synchronisation and Data-Available Controller

This block sits between a radio-data block decoder and the host-facing read registers. Each time the decoder finishes a 26-bit block, it presents a one-cycle event with the block's position in the group, an uncorrectable-error flag and the 16-bit information word. The controller keeps track of whether the receiver is still searching for block alignment or is synchronised. In the synchronised state, a programmable flywheel holds synchronisation through short error bursts. A restart command forces a new search.

The controller also decides which blocks are passed to the host. A two-bit protocol field selects one of three policies. The standard policy hands over every block once synchronised. The fast identifier-search policy also hands over error-free A blocks while still searching. The half-rate policy hands over every second block once synchronised. Each hand-over pulses a load strobe, moves the last-block register into the previous-block register, captures the new word and pulls the active-low data-available line low. The line returns high when the host begins a status read, or after a fixed number of clock cycles.

Top module: `rds_sync_ctrl`

## Requirements
- R1: With protocol 00 and the controller searching, no block causes a load strobe, and dav_n stays high.
- R2: When synchronised with protocol 00 or 01, every block event produces a hand-over, whether or not its error flag is set.
- R3: With protocol 01 and the controller searching, a block causes a hand-over only when blk_type is 0 (A block) and blk_err is low.
- R4: With protocol 10, searching produces no hand-over. When synchronised, hand-overs happen on every second block, counted from the block after synchronisation is gained, so the 2nd, 4th and later blocks are handed over.
- R5: While searching, synchronised goes high after an error-free block whose blk_type equals the previous error-free block's type plus one, modulo 4, provided no erroneous block came between them. Types are encoded 0=A, 1=B, 2=C, 3=D.
- R6: While synchronised, an error-free block clears the error-block count, and an erroneous block increments it. An erroneous block that would take the count above fly_limit (0 to 63) returns the controller to search, so fly_limit+1 consecutive erroneous blocks drop synchronisation.
- R7: A restart pulse returns the controller to search one cycle later, clears its history and suppresses any block event that arrives in the same cycle.
- R8: A hand-over raises ld_strobe for exactly one cycle. In that same cycle, prev_blk shows the former last_blk and last_blk shows the new blk_data.
- R9: A host_rd pulse while dav_n is low, with no block event in that cycle, returns dav_n high one cycle later.
- R10: Without a host read, dav_n stays low for exactly TMO_CYC cycles after a hand-over and then returns high.
- R11: Protocol 11 behaves exactly like protocol 00.
- R12: After reset, dav_n is high, synchronised and ld_strobe are low, and last_blk and prev_blk are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_valid | input | 1 | One-cycle block event from the decoder |
| blk_type | input | 2 | Block position: 0=A, 1=B, 2=C, 3=D |
| blk_err | input | 1 | Block has an uncorrectable error |
| blk_data | input | DATA_W | Information word of the block |
| proto_sel | input | 2 | Hand-over protocol: 00 standard, 01 fast A search, 10 half rate, 11 as 00 |
| fly_limit | input | FLY_W | Erroneous blocks tolerated while synchronised |
| restart | input | 1 | Force a return to search |
| host_rd | input | 1 | Host starts reading the status register |
| dav_n | output | 1 | Data available, active low |
| synced | output | 1 | Synchronised state |
| ld_strobe | output | 1 | One-cycle load pulse for the read registers |
| last_blk | output | DATA_W | Most recently handed-over block |
| prev_blk | output | DATA_W | Block handed over before last_blk |

## Verification
The properties assume several things about the inputs. Block events are single-cycle pulses. Restart and host reads never land in the same cycle as a block event. The protocol field is held steady while blocks are arriving. The stimulus respects all of these by spacing blocks several idle cycles apart and issuing restart and host reads only in the gaps. It changes protocol and flywheel limit only between runs, each run following a restart.

// File: rtl/rds_sync_ctrl.sv
module rds_sync_ctrl #(
  parameter int DATA_W  = 16,
  parameter int FLY_W   = 6,
  parameter int TMO_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  input  logic [1:0]        blk_type,
  input  logic              blk_err,
  input  logic [DATA_W-1:0] blk_data,
  input  logic [1:0]        proto_sel,
  input  logic [FLY_W-1:0]  fly_limit,
  input  logic              restart,
  input  logic              host_rd,
  output logic              dav_n,
  output logic              synced,
  output logic              ld_strobe,
  output logic [DATA_W-1:0] last_blk,
  output logic [DATA_W-1:0] prev_blk
);

  localparam int TW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  logic             sync_q, hist_ok_q, pair_q;
  logic [1:0]       hist_type_q;
  logic [FLY_W-1:0] err_cnt_q;
  logic [TW-1:0]    tmo_q;
  logic             dav_n_q;

  wire blk_live = blk_valid & ~restart;
  wire in_order = hist_ok_q && (blk_type == hist_type_q + 2'd1);
  wire fly_over = err_cnt_q >= fly_limit;
  wire srch_ev  = (proto_sel == 2'b01) && (blk_type == 2'd0) && !blk_err;
  wire sync_ev  = (proto_sel == 2'b10) ? pair_q : 1'b1;
  wire hand_ev  = blk_live && (sync_q ? sync_ev : srch_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 1'b0;
      hist_ok_q   <= 1'b0;
      hist_type_q <= 2'd0;
      err_cnt_q   <= '0;
      pair_q      <= 1'b0;
    end else if (restart) begin
      sync_q    <= 1'b0;
      hist_ok_q <= 1'b0;
      err_cnt_q <= '0;
      pair_q    <= 1'b0;
    end else if (blk_valid) begin
      if (sync_q) begin
        pair_q <= ~pair_q;
        if (!blk_err) begin
          err_cnt_q <= '0;
        end else if (fly_over) begin
          sync_q    <= 1'b0;
          err_cnt_q <= '0;
          hist_ok_q <= 1'b0;
        end else begin
          err_cnt_q <= err_cnt_q + 1'b1;
        end
      end else if (blk_err) begin
        hist_ok_q <= 1'b0;
      end else begin
        hist_ok_q   <= 1'b1;
        hist_type_q <= blk_type;
        if (in_order) begin
          sync_q    <= 1'b1;
          err_cnt_q <= '0;
          pair_q    <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_strobe <= 1'b0;
      last_blk  <= '0;
      prev_blk  <= '0;
      dav_n_q   <= 1'b1;
      tmo_q     <= '0;
    end else begin
      ld_strobe <= hand_ev;
      if (hand_ev) begin
        last_blk <= blk_data;
        prev_blk <= last_blk;
        dav_n_q  <= 1'b0;
        tmo_q    <= '0;
      end else if (!dav_n_q) begin
        if (host_rd || tmo_q == TMO_LAST) dav_n_q <= 1'b1;
        else                              tmo_q   <= tmo_q + 1'b1;
      end
    end
  end

  assign dav_n  = dav_n_q;
  assign synced = sync_q;

endmodule

// File: rtl/rds_sync_ctrl_chk.sv
module rds_sync_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_valid,
  input logic [1:0]        proto_sel,
  input logic              restart,
  input logic              host_rd,
  input logic              dav_n,
  input logic              synced,
  input logic              ld_strobe,
  input logic [DATA_W-1:0] last_blk,
  input logic [DATA_W-1:0] prev_blk
);

  AST_SEARCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !synced && proto_sel != 2'b01) |=> !ld_strobe); // R1

  AST_SYNC_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !restart && synced && proto_sel != 2'b10) |=> ld_strobe); // R2

  AST_RESTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!synced && !ld_strobe)); // R7

  AST_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |-> (prev_blk == $past(last_blk) && !dav_n)); // R8

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_strobe && !blk_valid) |=> !ld_strobe); // R8

  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !blk_valid) |=> dav_n); // R9

endmodule

bind rds_sync_ctrl rds_sync_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .proto_sel(proto_sel),
  .restart(restart), .host_rd(host_rd), .dav_n(dav_n), .synced(synced),
  .ld_strobe(ld_strobe), .last_blk(last_blk), .prev_blk(prev_blk)
);

// File: tb/test_rds_sync_ctrl.sv
`timescale 1ns/1ps
module test_rds_sync_ctrl;
  localparam int DW  = 16;
  localparam int FW  = 6;
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_valid = 1'b0, blk_err = 1'b0, restart = 1'b0, host_rd = 1'b0;
  logic [1:0]    blk_type = '0, proto_sel = '0;
  logic [DW-1:0] blk_data = '0;
  logic [FW-1:0] fly_limit = '0;
  logic          dav_n, synced, ld_strobe;
  logic [DW-1:0] last_blk, prev_blk;

  int checks = 0, failures = 0;
  bit done = 0;

  bit m_sync, m_hok, m_pair;
  int m_htype, m_cnt;
  logic [DW-1:0] m_last, m_prev;

  rds_sync_ctrl #(.DATA_W(DW), .FLY_W(FW), .TMO_CYC(TMO)) i_rds_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_type(blk_type),
    .blk_err(blk_err), .blk_data(blk_data), .proto_sel(proto_sel),
    .fly_limit(fly_limit), .restart(restart), .host_rd(host_rd),
    .dav_n(dav_n), .synced(synced), .ld_strobe(ld_strobe),
    .last_blk(last_blk), .prev_blk(prev_blk)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_sync = 0; m_hok = 0; m_cnt = 0; m_pair = 0;
    chk(synced == 1'b0, "R7 restart", synced, 0);
  endtask

  task automatic host_read();
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk(dav_n == 1'b1, "R9 host read", dav_n, 1);
    chk(ld_strobe == 1'b0, "R8 single pulse", ld_strobe, 0);
  endtask

  function automatic string ev_tag(input int m, input bit s);
    if (m == 2) return "R4";
    if (m == 3) return "R11";
    if (s) return "R2";
    return (m == 1) ? "R3" : "R1";
  endfunction

  task automatic send_blk(input int t, input bit e, input logic [DW-1:0] d, input int m, input int lim);
    bit ev;
    string tag;
    ev  = m_sync ? ((m == 2) ? m_pair : 1'b1) : (m == 1 && t == 0 && !e);
    tag = ev_tag(m, m_sync);
    if (m_sync) begin
      m_pair = !m_pair;
      if (!e) m_cnt = 0;
      else if (m_cnt + 1 > lim) begin m_sync = 0; m_cnt = 0; m_hok = 0; end
      else m_cnt++;
    end else if (e) begin
      m_hok = 0;
    end else begin
      if (m_hok && t == ((m_htype + 1) % 4)) begin m_sync = 1; m_cnt = 0; m_pair = 0; end
      m_hok = 1; m_htype = t;
    end
    if (ev) begin m_prev = m_last; m_last = d; end
    blk_valid = 1'b1; blk_type = 2'(t); blk_err = e; blk_data = d;
    @(negedge clk);
    blk_valid = 1'b0; blk_err = 1'b0;
    chk(synced == m_sync, "R5 R6 sync state", synced, m_sync);
    chk(ld_strobe == ev, tag, ld_strobe, ev);
    chk(dav_n == !ev, tag, dav_n, !ev);
    chk(last_blk == m_last, "R8 last", last_blk, m_last);
    chk(prev_blk == m_prev, "R8 prev", prev_blk, m_prev);
    if (ev) host_read();
    idle(2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lims[3] = '{0, 2, 5};
    m_sync = 0; m_hok = 0; m_pair = 0; m_htype = 0; m_cnt = 0;
    m_last = '0; m_prev = '0;
    idle(3);
    chk(dav_n == 1'b1, "R12 dav_n", dav_n, 1);
    chk(synced == 1'b0, "R12 synced", synced, 0);
    chk(ld_strobe == 1'b0, "R12 strobe", ld_strobe, 0);
    chk(last_blk == '0 && prev_blk == '0, "R12 regs", last_blk, 0);
    rst_n = 1'b1;
    idle(2);

    for (int m = 0; m < 4; m++) begin
      for (int li = 0; li < 3; li++) begin
        int ord;
        proto_sel = 2'(m);
        fly_limit = FW'(lims[li]);
        idle(1);
        do_restart();
        ord = (m == 1) ? 3 : 0;
        for (int i = 0; i < 40; i++) begin
          int t;
          bit e;
          t = (i % 13 == 9) ? (ord + 2) % 4 : ord;
          ord = (t + 1) % 4;
          e = (i % 9 == 4) || (i >= 20 && i < 24);
          send_blk(t, e, DW'(16'hA000 ^ (m << 12) ^ (lims[li] << 8) ^ i), m, lims[li]);
        end
      end
    end

    proto_sel = 2'b00;
    do_restart();
    send_blk(0, 0, 16'h1111, 0, 2);
    send_blk(1, 0, 16'h2222, 0, 2);
    chk(synced == 1'b1, "R5 acquired", synced, 1);
    blk_valid = 1'b1; blk_type = 2'd2; blk_err = 1'b0; blk_data = 16'h3333;
    m_prev = m_last; m_last = 16'h3333;
    @(negedge clk);
    blk_valid = 1'b0;
    chk(dav_n == 1'b0, "R10 low at start", dav_n, 0);
    idle(TMO - 1);
    chk(dav_n == 1'b0, "R10 low before timeout", dav_n, 0);
    idle(1);
    chk(dav_n == 1'b1, "R10 released by timeout", dav_n, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule